// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable behavioural model of a pipelined synchronous SRAM that needs no idle cycle when the bus changes direction. It is meant for verification environments that need a realistic memory behind a controller. Each word is 18 bits wide and is split into two 9-bit lanes. Each lane holds 8 data bits and one parity bit. Lane 0 occupies bits [8:0], with its parity bit at bit 8. Lane 1 occupies bits [17:9]. The number of address bits is a parameter.

Every access has a fixed timing relative to the clock edge that samples its address:

- The next enabled edge moves the access into a second stage.
- A read drives its word on the bus between the first and second enabled edges after the address edge. The controller captures it at the second edge.
- A write expects its data on the bus in that same window and captures it at the second edge.

Because reads and writes use the same data slot, they can alternate on consecutive cycles.

A load cycle captures a new address and a new operation. Advance cycles then step a 2-bit offset through a burst of up to four words, in linear or interleaved order. A clock-enable input stretches the current cycle. A sleep input freezes the whole core and preserves its contents. The data bus is split into an input vector and an output vector with a drive flag. An enclosing wrapper turns them into a tri-state bus.

Top module: `burst_sram`

## Requirements
- R1: A synchronous reset empties both pipeline stages and clears the burst state. After reset, `dq_oe` is 0, `dq_o` is 0, and an advance cycle performs no access.
- R2: When `clken_n` is 1 at a clock edge, that edge is ignored. Captured commands, the burst offset and the pipeline all hold. A read word already on the bus stays driven and unchanged.
- R3: A load edge selects the device only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 together. Any other combination is a deselect and makes no access.
- R4: `burst_adv`=0 loads a new address and operation. `burst_adv`=1 repeats the loaded operation at the next burst offset, changing only the two lowest address bits. An advance after a deselect or a reset performs no access.
- R5: Advance n (n = 1, 2, 3, then wrapping) uses offset (start + n) mod 4 when `order_ilv`=0, and start XOR n when `order_ilv`=1. Here start is bits [1:0] of the loaded address.
- R6: A read issued at an enabled edge drives its word on `dq_o`, with `dq_oe`=1, after the next enabled edge. It is captured at the enabled edge after that. `dq_oe` is 1 only while `out_en_n`=0.
- R7: A load with `wr_n`=0 is a write, and `dq_i` is captured at the second enabled edge after the address. `lane_wr_n[0]`=0 writes bits [8:0] and `lane_wr_n[1]`=0 writes bits [17:9]. A lane whose strobe is 1 keeps its old contents. `dq_oe` is 0 during the write data slot.
- R8: `dq_oe` is 0 whenever the data slot holds no read. This includes every slot after a deselect and the first slot after the device is selected again.
- R9: A read issued on the edge right after a write returns the written lanes of that write, with no idle cycle. A write issued right after a read does not disturb that read's data.
- R10: While `sleep`=1, clock edges are ignored, all inputs are ignored, `dq_oe` is 0, and the memory and pipeline contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the control state |
| addr | input | ADDR_W | Word address, sampled on load edges |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read, sampled on load edges |
| lane_wr_n | input | 2 | Per-lane write strobes, active low |
| burst_adv | input | 1 | 0 = load new address, 1 = advance burst |
| clken_n | input | 1 | Clock enable, active low |
| order_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Retention mode, active high |
| dq_i | input | 18 | Write data from the bus |
| dq_o | output | 18 | Read data to the bus |
| dq_oe | output | 1 | Drive enable for the bus |

## Verification
The bench targets a read issued on the edge right after a write to the same word. A model without forwarding would return the stale word. It also exercises partial lane writes and a write with both strobes high. A wrong lane mask would corrupt the neighbouring lane or its parity bit. Bursts are run in both orders, including a linear burst that wraps from offset 3 to 0. A swapped order or a carry into bit 2 would return data from the wrong word. Clock-enable stalls in mid-burst, sleep, each invalid select combination and an advance after a deselect are each checked at the bus. A design that let any of these through would drive data or write memory in a slot that must stay quiet.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [LANES-1:0] lane_we;
    } op_t;

    // Offset of the n-th word of a burst that began at 'start'.
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input burst_order_e ord);
        if (ord == ORD_INTERLEAVE)
            return start ^ step;
        else
            return start + step;
    endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              burst_adv,
    input  logic              order_ilv,
    output op_t               s1_op,
    output logic [ADDR_W-1:0] s1_addr
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        step_q, step_d, step_inc;
    logic              active_q, active_d;
    logic              last_wr_q, last_wr_d;
    logic              selected;
    op_t               nxt_op;
    logic [ADDR_W-1:0] nxt_addr;
    burst_order_e      ord;

    assign selected = !sel_a_n && sel_b && !sel_c_n;
    assign step_inc = step_q + 2'd1;
    assign ord      = burst_order_e'(order_ilv);

    always_comb begin
        nxt_op    = '0;
        nxt_addr  = s1_addr;
        base_d    = base_q;
        step_d    = step_q;
        active_d  = active_q;
        last_wr_d = last_wr_q;
        if (!burst_adv) begin
            if (selected) begin
                nxt_op.valid   = 1'b1;
                nxt_op.wr      = !wr_n;
                nxt_op.lane_we = wr_n ? '0 : ~lane_wr_n;
                nxt_addr       = addr;
                base_d         = addr;
                step_d         = 2'd0;
                active_d       = 1'b1;
                last_wr_d      = !wr_n;
            end else begin
                active_d = 1'b0;
            end
        end else if (active_q) begin
            step_d         = step_inc;
            nxt_op.valid   = 1'b1;
            nxt_op.wr      = last_wr_q;
            nxt_op.lane_we = last_wr_q ? ~lane_wr_n : '0;
            nxt_addr       = {base_q[ADDR_W-1:2],
                              burst_offset(base_q[1:0], step_inc, ord)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op     <= '0;
            s1_addr   <= '0;
            base_q    <= '0;
            step_q    <= 2'd0;
            active_q  <= 1'b0;
            last_wr_q <= 1'b0;
        end else if (adv_en) begin
            s1_op     <= nxt_op;
            s1_addr   <= nxt_addr;
            base_q    <= base_d;
            step_q    <= step_d;
            active_q  <= active_d;
            last_wr_q <= last_wr_d;
        end
    end

    // R2: a masked edge leaves the captured command untouched
    assert_stall_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> ($stable(s1_op) && $stable(s1_addr)));

    // R3: a deselecting load edge yields no access
    assert_deselect_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !burst_adv && !selected) |=> !s1_op.valid);

    // R4: an advance inside a burst keeps the upper address bits
    assert_burst_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_en && burst_adv && active_q)
            |=> (s1_op.valid &&
                 s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  op_t               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] rd_data,
    output logic              drive_q
);

    op_t               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [WORD_W-1:0] fwd_word;
    logic              s2_hit;

    // A write committing on this edge to the word being read is forwarded.
    assign s2_hit = s2_op.valid && s2_op.wr && (s2_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank_q;
        logic              lane_we;

        assign lane_we = adv_en && s2_op.valid && s2_op.wr && s2_op.lane_we[g];

        burst_sram_lane #(
            .ADDR_W(ADDR_W),
            .WIDTH (LANE_W)
        ) u_bank (
            .clk  (clk),
            .we   (lane_we),
            .waddr(s2_addr),
            .wdata(dq_i[g*LANE_W +: LANE_W]),
            .raddr(s1_addr),
            .rdata(bank_q)
        );

        assign fwd_word[g*LANE_W +: LANE_W] =
            (s2_hit && s2_op.lane_we[g]) ? dq_i[g*LANE_W +: LANE_W] : bank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= '0;
            s2_addr <= '0;
            rd_data <= '0;
            drive_q <= 1'b0;
        end else if (adv_en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            drive_q <= s1_op.valid && !s1_op.wr;
            if (s1_op.valid && !s1_op.wr)
                rd_data <= fwd_word;
        end
    end

    // R6: the bus is only turned on by a read leaving the first stage
    assert_drive_from_read_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_q) |-> $past(adv_en && s1_op.valid && !s1_op.wr));

    // R7: the write data slot never drives the bus
    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (s2_op.valid && s2_op.wr) |-> !drive_q);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              burst_adv,
    input  logic              clken_n,
    input  logic              order_ilv,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    logic              adv_en;
    op_t               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [WORD_W-1:0] rd_data;
    logic              drive_q;

    assign adv_en = !clken_n && !sleep;

    burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (adv_en),
        .addr     (addr),
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .sel_c_n  (sel_c_n),
        .wr_n     (wr_n),
        .lane_wr_n(lane_wr_n),
        .burst_adv(burst_adv),
        .order_ilv(order_ilv),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr)
    );

    burst_sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .adv_en (adv_en),
        .s1_op  (s1_op),
        .s1_addr(s1_addr),
        .dq_i   (dq_i),
        .rd_data(rd_data),
        .drive_q(drive_q)
    );

    assign dq_o  = rd_data;
    assign dq_oe = drive_q && !out_en_n && !sleep;

    // R10: sleep freezes the read data register
    assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(rd_data));

endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic        burst_adv = 1'b0, clken_n = 1'b0, order_ilv = 1'b0;
    logic        out_en_n = 1'b0, sleep = 1'b0;
    logic [17:0] dq_i = '0;
    logic [17:0] dq_o;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .burst_adv(burst_adv), .clken_n(clken_n), .order_ilv(order_ilv),
        .out_en_n(out_en_n), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe)
    );

    // vector: {kind[1:0], ilv, lanes_n[1:0], addr[7:0], data[17:0]}
    // kind 0 = deselect, 1 = load read, 2 = load write, 3 = advance
    function automatic logic [30:0] mkv(input logic [1:0] k, input logic ilv,
                                        input logic [1:0] ln, input logic [7:0] a,
                                        input logic [17:0] d);
        return {k, ilv, ln, a, d};
    endfunction

    localparam int NV = 23;
    localparam logic [30:0] VEC [NV] = '{
        mkv(2'd2, 1'b0, 2'b00, 8'h10, 18'h2A5A5),
        mkv(2'd1, 1'b0, 2'b11, 8'h10, 18'h0),
        mkv(2'd2, 1'b0, 2'b00, 8'h20, 18'h00000),
        mkv(2'd1, 1'b0, 2'b11, 8'h10, 18'h0),
        mkv(2'd2, 1'b0, 2'b10, 8'h20, 18'h3FFFF),
        mkv(2'd1, 1'b0, 2'b11, 8'h20, 18'h0),
        mkv(2'd2, 1'b0, 2'b01, 8'h20, 18'h2AA00),
        mkv(2'd1, 1'b0, 2'b11, 8'h20, 18'h0),
        mkv(2'd2, 1'b0, 2'b11, 8'h10, 18'h3FFFF),
        mkv(2'd1, 1'b0, 2'b11, 8'h10, 18'h0),
        mkv(2'd2, 1'b0, 2'b00, 8'h42, 18'h01111),
        mkv(2'd3, 1'b0, 2'b00, 8'h00, 18'h02222),
        mkv(2'd3, 1'b0, 2'b00, 8'h00, 18'h03333),
        mkv(2'd3, 1'b0, 2'b00, 8'h00, 18'h04444),
        mkv(2'd1, 1'b1, 2'b11, 8'h42, 18'h0),
        mkv(2'd3, 1'b1, 2'b11, 8'h00, 18'h0),
        mkv(2'd3, 1'b1, 2'b11, 8'h00, 18'h0),
        mkv(2'd3, 1'b1, 2'b11, 8'h00, 18'h0),
        mkv(2'd1, 1'b0, 2'b11, 8'h43, 18'h0),
        mkv(2'd3, 1'b0, 2'b11, 8'h00, 18'h0),
        mkv(2'd3, 1'b0, 2'b11, 8'h00, 18'h0),
        mkv(2'd0, 1'b0, 2'b11, 8'h00, 18'h0),
        mkv(2'd0, 1'b0, 2'b11, 8'h00, 18'h0)
    };

    logic [17:0] ref_mem [256];
    logic [17:0] exp_rd  [NV];
    logic [17:0] wr_word [NV];
    bit          is_rd   [NV];
    bit          is_wr   [NV];

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic ilv, input logic [1:0] ln,
                         input logic [7:0] a);
        order_ilv = ilv;
        lane_wr_n = ln;
        addr      = a;
        burst_adv = (k == 2'd3);
        wr_n      = (k != 2'd2);
        if (k == 2'd0) begin
            sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        end else begin
            sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic flush();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        tick();
    endtask

    // Reference model built from R4, R5, R7, R9.
    task automatic build_ref();
        logic [7:0] base = '0;
        logic [1:0] step = '0;
        bit         act  = 0;
        bit         cwr  = 0;
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k  = VEC[i][30:29];
            logic        il = VEC[i][28];
            logic [1:0]  ln = VEC[i][27:26];
            logic [7:0]  a  = VEC[i][25:18];
            logic [17:0] d  = VEC[i][17:0];
            bit          op = 0;
            is_rd[i] = 0; is_wr[i] = 0; exp_rd[i] = '0; wr_word[i] = d;
            if (k == 2'd1 || k == 2'd2) begin
                base = a; step = 2'd0; act = 1; cwr = (k == 2'd2); op = 1;
            end else if (k == 2'd3) begin
                if (act) begin
                    step = step + 2'd1;
                    a = {base[7:2], il ? (base[1:0] ^ step) : (base[1:0] + step)};
                    op = 1;
                end
            end else begin
                act = 0;
            end
            if (op) begin
                if (cwr) begin
                    is_wr[i] = 1;
                    if (!ln[0]) ref_mem[a][8:0]  = d[8:0];
                    if (!ln[1]) ref_mem[a][17:9] = d[17:9];
                end else begin
                    is_rd[i] = 1;
                    exp_rd[i] = ref_mem[a];
                end
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        build_ref();

        // R1: reset state
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R1 reset dq_oe", {17'd0, dq_oe}, 18'd0);
        chk("R1 reset dq_o", dq_o, 18'd0);
        // R1: advance right after reset does nothing
        drive(2'd3, 1'b0, 2'b11, 8'h00);
        tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        chk("R1 advance after reset", {17'd0, dq_oe}, 18'd0);
        tick();

        // Vector table: R4 R5 R7 R8 R9 and R6 timing
        for (int i = 0; i < NV + 2; i++) begin
            if (i < NV)
                drive(VEC[i][30:29], VEC[i][28], VEC[i][27:26], VEC[i][25:18]);
            else
                drive(2'd0, 1'b0, 2'b11, 8'h00);
            dq_i = (i >= 2 && is_wr[i-2]) ? wr_word[i-2] : 18'h0;
            tick();
            if (i >= 1 && i - 1 < NV) begin
                chk($sformatf("R6/R8 vec%0d dq_oe", i - 1), {17'd0, dq_oe},
                    {17'd0, is_rd[i-1]});
                if (is_rd[i-1])
                    chk($sformatf("R5/R7/R9 vec%0d data", i - 1), dq_o, exp_rd[i-1]);
            end
        end
        dq_i = '0;
        flush();

        // R6: output enable gating, R8: first slot after reselect is quiet
        drive(2'd1, 1'b0, 2'b11, 8'h20);
        tick();
        chk("R8 first slot after reselect", {17'd0, dq_oe}, 18'd0);
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        out_en_n = 1'b1; #1;
        chk("R6 out_en_n high", {17'd0, dq_oe}, 18'd0);
        out_en_n = 1'b0; #1;
        chk("R6 out_en_n low", {17'd0, dq_oe}, 18'd1);
        chk("R6 read data", dq_o, 18'h2ABFF);
        tick();
        chk("R8 slot after read", {17'd0, dq_oe}, 18'd0);

        // R3: each invalid select combination
        for (int v = 0; v < 3; v++) begin
            drive(2'd1, 1'b0, 2'b11, 8'h10);
            if (v == 0) sel_a_n = 1'b1;
            if (v == 1) sel_b   = 1'b0;
            if (v == 2) sel_c_n = 1'b1;
            tick();
            drive(2'd0, 1'b0, 2'b11, 8'h00);
            tick();
            chk($sformatf("R3 select variant %0d", v), {17'd0, dq_oe}, 18'd0);
        end

        // R4: advance after deselect makes no access
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        drive(2'd3, 1'b0, 2'b11, 8'h00);
        tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        chk("R4 advance after deselect", {17'd0, dq_oe}, 18'd0);
        flush();

        // R2: stalls in the middle of a linear read burst at 0x40
        drive(2'd1, 1'b0, 2'b11, 8'h40);
        tick();
        drive(2'd3, 1'b0, 2'b11, 8'h00);
        clken_n = 1'b1;
        tick();
        chk("R2 stall before data", {17'd0, dq_oe}, 18'd0);
        tick();
        chk("R2 second stall", {17'd0, dq_oe}, 18'd0);
        clken_n = 1'b0;
        tick();
        chk("R2 word0 after stall", dq_o, 18'h03333);
        clken_n = 1'b1;
        tick();
        chk("R2 held drive", {17'd0, dq_oe}, 18'd1);
        chk("R2 held data", dq_o, 18'h03333);
        clken_n = 1'b0;
        tick();
        chk("R2 R5 word1", dq_o, 18'h04444);
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        chk("R2 R5 word2", dq_o, 18'h01111);
        tick();
        chk("R8 after burst", {17'd0, dq_oe}, 18'd0);
        flush();

        // R10: sleep with a read in flight
        drive(2'd1, 1'b0, 2'b11, 8'h10);
        tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        sleep = 1'b1;
        tick();
        chk("R10 sleep bus off", {17'd0, dq_oe}, 18'd0);
        tick();
        chk("R10 sleep bus off 2", {17'd0, dq_oe}, 18'd0);
        sleep = 1'b0;
        tick();
        chk("R10 read resumes", {17'd0, dq_oe}, 18'd1);
        chk("R10 read data kept", dq_o, 18'h2A5A5);
        flush();

        // R10: a write presented during sleep is ignored
        sleep = 1'b1;
        drive(2'd2, 1'b0, 2'b00, 8'h10);
        dq_i = 18'h3FFFF;
        tick(); tick(); tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        sleep = 1'b0;
        tick(); tick(); tick();
        dq_i = '0;
        drive(2'd1, 1'b0, 2'b11, 8'h10);
        tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        tick();
        chk("R10 write ignored", dq_o, 18'h2A5A5);
        flush();

        // R1: reset with a read in flight
        drive(2'd1, 1'b0, 2'b11, 8'h20);
        tick();
        drive(2'd0, 1'b0, 2'b11, 8'h00);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset clears read", {17'd0, dq_oe}, 18'd0);
        tick();
        chk("R1 stays quiet", {17'd0, dq_oe}, 18'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule